// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is a clocked model of a serial EEPROM that answers an SPI master in mode 0. A fast system clock oversamples the four bus inputs (serial clock, active-low select, active-low hold and serial data in) through two-flop synchronizers. It finds rising serial-clock edges and shifts data in and out on them. Every sampled bit and every bit on the output goes most significant bit first. The system clock must run at least four times faster than the serial clock.

The block accepts six one-byte commands. Write enable and write disable set and clear an enable latch. The status byte can be read, and its two protect bits can be written. A data read takes a 16-bit address and then streams bytes. A data write takes a 16-bit address and then programs bytes. The storage is an internal byte array of 2^ADDR_W entries. A data write only stores a byte when the enable latch is set and the target quarter of the array is not protected. Sequential writes stay inside a 2^PAGE_W-byte page. Sequential reads run across the whole array.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, and whenever `cs_n` is high while `hold_n` is high, the block goes back to collecting an opcode, clears its bit count and drives `so` high.
- R2: Each bit on `si` is captured on a rising `sclk` edge, most significant bit first. `so` changes only after a rising `sclk` edge and carries bit 7 of each outgoing byte first.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Any further clocks in the same selection are ignored.
- R4: An opcode other than 0x01–0x06 makes the block ignore the rest of the selection, and `so` stays high.
- R5: Opcode 0x05 shifts out the status byte. Bit 1 is the write-enable latch, bits 3:2 are the protect code, and bits 7:4 and bit 0 read as zero. The same byte repeats while clocking continues.
- R6: Opcode 0x01 followed by one byte copies bits 3:2 of that byte into the protect code. It leaves the write-enable latch unchanged and discards the other bits.
- R7: Opcode 0x03 is followed by a 16-bit address. Only its low ADDR_W bits are used. Bytes then stream out from consecutive addresses, and the address wraps from the last location to 0.
- R8: Opcode 0x02 is followed by a 16-bit address and then data bytes. A byte is stored only while the write-enable latch is set. Writing data does not change the latch.
- R9: The protect code decides which addresses block a write, using the top two address bits. Code 00 blocks nothing. Code 01 blocks the top quarter (bits = 11). Code 10 blocks the upper half (top bit = 1). Code 11 blocks the whole array.
- R10: After each data byte of a write, only the low PAGE_W address bits increase, modulo 2^PAGE_W. The higher bits stay fixed, so a burst wraps inside its page.
- R11: While `hold_n` is low, changes on `sclk`, `si` and `cs_n` have no effect. The `sclk` level is still tracked, so if `sclk` is already high when hold ends, that level does not count as a rising edge.
- R12: Raising `cs_n` in the middle of a byte discards the bits shifted so far and programs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low device select |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master, high when idle |

## Verification
The bench builds the block with ADDR_W = 10 and PAGE_W = 7. This gives a 1 KB array of eight 128-byte pages. The quarter boundaries at 0x200 and 0x300, and the array end at 0x3FF, are then a few transactions away. This is enough to check every protect code at addresses just below and just above each boundary. It also checks a read stream that wraps from 0x3FF back to 0x000. A masked high address (0xFC7E) shows that the upper address bits are ignored. A four-byte burst that starts two bytes before a page end shows the in-page write wrap, while the first byte of the next page stays untouched.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam int OPCODE_BITS    = 8;
    localparam int WIRE_ADDR_BITS = 16;
    localparam int CNT_W          = $clog2(WIRE_ADDR_BITS);
    localparam int OPC_LAST       = OPCODE_BITS - 1;
    localparam int ADDR_LAST      = WIRE_ADDR_BITS - 1;

    localparam logic [7:0] OP_STATUS_WR = 8'h01;
    localparam logic [7:0] OP_DATA_WR   = 8'h02;
    localparam logic [7:0] OP_DATA_RD   = 8'h03;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STATUS_RD = 8'h05;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_IDLE
    } state_e;

    typedef enum logic [1:0] {
        CMD_STATUS_WR,
        CMD_DATA_WR,
        CMD_DATA_RD,
        CMD_STATUS_RD
    } cmd_e;

    typedef struct packed {
        logic [1:0] bp;
        logic       wel;
    } status_t;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic hold_n;
        logic si;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, hold_n: 1'b1, si: 1'b0};

    function automatic logic [7:0] status_byte(status_t s);
        return {4'b0000, s.bp, s.wel, 1'b0};
    endfunction

    function automatic logic quarter_blocked(logic [1:0] bp, logic [1:0] quarter);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return quarter == 2'b11;
            2'b10:   return quarter[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/spi_eeprom_edge.sv
module spi_eeprom_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2
endmodule

// File: rtl/spi_eeprom_mem.sv
module spi_eeprom_mem #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              cs_n_i,
    input  logic              hold_n_i,
    input  logic              si_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_waddr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              so_o
);
    localparam logic [CNT_W-1:0] CNT_OPC_LAST  = CNT_W'(OPC_LAST);
    localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_LAST);

    state_e              state_q;
    cmd_e                cmd_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [OPCODE_BITS-2:0] op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          buf_q;
    status_t             status_q;
    logic                so_q;

    logic                step;
    logic [7:0]          opcode_full;
    logic [7:0]          byte_full;
    logic [ADDR_W-1:0]   addr_shift;
    logic [ADDR_W-1:0]   addr_page_next;
    logic                byte_last;

    always_comb begin
        step           = hold_n_i && !cs_n_i && rise_i;
        opcode_full    = {op_q, si_i};
        byte_full      = {buf_q[6:0], si_i};
        addr_shift     = {addr_q[ADDR_W-2:0], si_i};
        addr_page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
        byte_last      = (cnt_q == CNT_OPC_LAST);
    end

    always_comb begin
        if (state_q == ST_ADDR) mem_raddr_o = addr_shift;
        else                    mem_raddr_o = addr_q + ADDR_W'(1);
    end

    assign mem_we_o    = step && (state_q == ST_WRITE) && (cmd_q == CMD_DATA_WR) && byte_last
                         && status_q.wel
                         && !quarter_blocked(status_q.bp, addr_q[ADDR_W-1 -: 2]);
    assign mem_waddr_o = addr_q;
    assign mem_wdata_o = byte_full;
    assign so_o        = so_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_OPCODE;
            cmd_q    <= CMD_DATA_RD;
            cnt_q    <= '0;
            op_q     <= '0;
            addr_q   <= '0;
            buf_q    <= '0;
            status_q <= '0;
            so_q     <= 1'b1;
        end else if (hold_n_i) begin
            if (cs_n_i) begin
                state_q <= ST_OPCODE;
                cnt_q   <= '0;
                op_q    <= '0;
                so_q    <= 1'b1;
            end else if (rise_i) begin
                case (state_q)
                    ST_OPCODE: begin
                        if (cnt_q == CNT_OPC_LAST) begin
                            cnt_q <= '0;
                            case (opcode_full)
                                OP_STATUS_WR: begin
                                    cmd_q   <= CMD_STATUS_WR;
                                    buf_q   <= '0;
                                    state_q <= ST_WRITE;
                                end
                                OP_DATA_WR: begin
                                    cmd_q   <= CMD_DATA_WR;
                                    addr_q  <= '0;
                                    state_q <= ST_ADDR;
                                end
                                OP_DATA_RD: begin
                                    cmd_q   <= CMD_DATA_RD;
                                    addr_q  <= '0;
                                    state_q <= ST_ADDR;
                                end
                                OP_LATCH_CLR: begin
                                    status_q.wel <= 1'b0;
                                    state_q      <= ST_IDLE;
                                end
                                OP_STATUS_RD: begin
                                    cmd_q   <= CMD_STATUS_RD;
                                    buf_q   <= status_byte(status_q);
                                    state_q <= ST_READ;
                                end
                                OP_LATCH_SET: begin
                                    status_q.wel <= 1'b1;
                                    state_q      <= ST_IDLE;
                                end
                                default: state_q <= ST_IDLE;
                            endcase
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            op_q  <= opcode_full[OPCODE_BITS-2:0];
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_shift;
                        if (cnt_q == CNT_ADDR_LAST) begin
                            cnt_q <= '0;
                            if (cmd_q == CMD_DATA_RD) begin
                                buf_q   <= mem_rdata_i;
                                state_q <= ST_READ;
                            end else begin
                                buf_q   <= '0;
                                state_q <= ST_WRITE;
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_WRITE: begin
                        if (byte_last) begin
                            cnt_q <= '0;
                            if (cmd_q == CMD_STATUS_WR) begin
                                status_q.bp <= byte_full[3:2];
                                state_q     <= ST_IDLE;
                            end else begin
                                buf_q  <= '0;
                                addr_q <= addr_page_next;
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            buf_q <= byte_full;
                        end
                    end
                    ST_READ: begin
                        so_q <= buf_q[3'd7 - cnt_q[2:0]];
                        if (byte_last) begin
                            cnt_q <= '0;
                            if (cmd_q == CMD_DATA_RD) begin
                                addr_q <= addr_q + ADDR_W'(1);
                                buf_q  <= mem_rdata_i;
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_DESELECT_SO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (hold_n_i && cs_n_i) |=> so_o); // R1
    AST_DESELECT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (hold_n_i && cs_n_i) |=> (state_q == ST_OPCODE && cnt_q == '0)); // R12
    AST_STORE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> status_q.wel); // R8
    AST_STORE_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !quarter_blocked(status_q.bp, mem_waddr_o[ADDR_W-1 -: 2])); // R9
    AST_PAGE_PINNED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |=> $stable(addr_q[ADDR_W-1:PAGE_W])); // R10
    AST_STATUS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> $stable(status_q)); // R6
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !hold_n_i |=> ($stable(state_q) && $stable(cnt_q) && $stable(status_q) && $stable(so_o))); // R11
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic hold_n,
    input  logic si,
    output logic so
);
    pins_t             pin_raw;
    pins_t             pin_s;
    logic              sclk_rise;
    logic [7:0]        mem_rdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    assign pin_raw = '{sclk: sclk, cs_n: cs_n, hold_n: hold_n, si: si};

    for (genvar i = 0; i < $bits(pins_t); i++) begin : g_sync
        spi_eeprom_sync #(.RST_VAL(PINS_IDLE[i])) u_sync (
            .clk (clk),
            .rst (rst),
            .d_i (pin_raw[i]),
            .q_o (pin_s[i])
        );
    end

    spi_eeprom_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (pin_s.sclk),
        .rise_o  (sclk_rise)
    );

    spi_eeprom_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (sclk_rise),
        .cs_n_i      (pin_s.cs_n),
        .hold_n_i    (pin_s.hold_n),
        .si_i        (pin_s.si),
        .mem_rdata_i (mem_rdata),
        .mem_raddr_o (mem_raddr),
        .mem_we_o    (mem_we),
        .mem_waddr_o (mem_waddr),
        .mem_wdata_o (mem_wdata),
        .so_o        (so)
    );

    spi_eeprom_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );
endmodule

// File: tb/spi_eeprom_slave_test.sv
`timescale 1ns/1ps
module spi_eeprom_slave_test;
    localparam int AW    = 10;
    localparam int PW    = 7;
    localparam int DEPTH = 1 << AW;
    localparam logic [15:0] PADDR [6] = '{16'h0000, 16'h01FF, 16'h0200, 16'h02FF, 16'h0300, 16'h03FF};

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic hold_n = 1'b1;
    logic si = 1'b0;
    logic so;

    int n_checks = 0;
    int n_fail = 0;
    exp_t exp_q[$];
    logic rd_active = 1'b0;
    logic [7:0] mon_sh = '0;
    int mon_n = 0;

    logic [7:0] ref_mem [DEPTH];
    logic       m_wel = 1'b0;
    logic [1:0] m_bp = 2'b00;

    always #4 clk = ~clk;

    spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW)) uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n), .si(si), .so(so)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: collect SO bits on falling SCLK and compare whole bytes with the scoreboard
    always @(negedge sclk) begin
        if (rd_active) begin
            mon_sh = {mon_sh[6:0], so};
            mon_n++;
            if (mon_n == 8) begin
                exp_t e;
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected byte", mon_sh, 8'h00);
                end else begin
                    e = exp_q.pop_front();
                    check(mon_sh === e.val, e.req, mon_sh, e.val);
                end
            end
        end
    end

    function automatic bit blocked(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'b01:   return a >= 10'h300;
            2'b10:   return a >= 10'h200;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] model_status();
        return {4'b0000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        si = b;
        wait_clks(3);
        sclk = 1'b1;
        wait_clks(4);
        sclk = 1'b0;
        wait_clks(1);
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    endtask

    task automatic select_dev();
        cs_n = 1'b0;
        wait_clks(4);
    endtask

    task automatic deselect_dev();
        wait_clks(4);
        cs_n = 1'b1;
        wait_clks(8);
    endtask

    task automatic cmd_only(input logic [7:0] op);
        select_dev();
        spi_byte(op);
        deselect_dev();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic write_status(input logic [7:0] v);
        select_dev();
        spi_byte(8'h01);
        spi_byte(v);
        deselect_dev();
        m_bp = v[3:2];
    endtask

    task automatic write_bytes(input logic [15:0] a, input int n, input logic [7:0] base);
        logic [AW-1:0] ad;
        ad = a[AW-1:0];
        select_dev();
        spi_byte(8'h02);
        spi_byte(a[15:8]);
        spi_byte(a[7:0]);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = base + 8'(k);
            spi_byte(v);
            if (m_wel && !blocked(m_bp, ad)) ref_mem[ad] = v;
            ad = {ad[AW-1:PW], ad[PW-1:0] + 7'd1};
        end
        deselect_dev();
    endtask

    task automatic read_bytes(input logic [15:0] a, input int n, input string tag);
        logic [AW-1:0] ad;
        exp_t e;
        ad = a[AW-1:0];
        for (int k = 0; k < n; k++) begin
            e.val = ref_mem[ad];
            e.req = tag;
            exp_q.push_back(e);
            ad = ad + 1'b1;
        end
        select_dev();
        spi_byte(8'h03);
        spi_byte(a[15:8]);
        spi_byte(a[7:0]);
        rd_active = 1'b1;
        repeat (n * 8) spi_bit(1'b0);
        rd_active = 1'b0;
        deselect_dev();
    endtask

    task automatic read_status(input int n, input string tag);
        exp_t e;
        for (int k = 0; k < n; k++) begin
            e.val = model_status();
            e.req = tag;
            exp_q.push_back(e);
        end
        select_dev();
        spi_byte(8'h05);
        rd_active = 1'b1;
        repeat (n * 8) spi_bit(1'b0);
        rd_active = 1'b0;
        deselect_dev();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(4);
        check(so === 1'b1, "R1 reset so", {7'd0, so}, 8'h01);

        read_status(1, "R5");

        // R8: latch off, then on, then off again
        write_bytes(16'h0010, 1, 8'h33);
        cmd_only(8'h06);
        read_status(1, "R3");
        write_bytes(16'h0010, 1, 8'h55);
        cmd_only(8'h04);
        read_status(1, "R3");
        write_bytes(16'h0010, 1, 8'hAA);
        read_bytes(16'h0010, 1, "R8 R2");

        // R6: status write with latch clear keeps it clear
        write_status(8'hFF);
        read_status(2, "R6");
        write_status(8'h00);

        // R3: extra clocks after write enable are ignored
        select_dev();
        spi_byte(8'h06);
        spi_byte(8'h04);
        deselect_dev();
        m_wel = 1'b1;
        read_status(2, "R5 R3");
        write_status(8'hF3);
        read_status(1, "R6");

        // R4: unsupported opcode
        select_dev();
        spi_byte(8'h9F);
        check(so === 1'b1, "R4 so after bad opcode", {7'd0, so}, 8'h01);
        spi_byte(8'h04);
        check(so === 1'b1, "R4 so while ignored", {7'd0, so}, 8'h01);
        deselect_dev();
        read_status(1, "R4");

        // R10: page wrap
        write_bytes(16'h0080, 1, 8'h99);
        write_bytes(16'h007E, 4, 8'hA0);
        read_bytes(16'h007E, 2, "R10");
        read_bytes(16'h0000, 2, "R10");
        read_bytes(16'h0080, 1, "R10");

        // R7: array wrap and address masking
        write_bytes(16'h03FE, 2, 8'hC0);
        read_bytes(16'h03FE, 4, "R7");
        read_bytes(16'hFC7E, 1, "R7");

        // R9: each protect code at the quarter boundaries
        for (int c = 0; c < 4; c++) begin
            write_status(8'h00);
            for (int i = 0; i < 6; i++) write_bytes(PADDR[i], 1, 8'(16 * c + i));
            write_status(8'(c << 2));
            for (int i = 0; i < 6; i++) write_bytes(PADDR[i], 1, 8'(128 + 16 * c + i));
            for (int i = 0; i < 6; i++) read_bytes(PADDR[i], 1, "R9");
        end
        write_status(8'h00);

        // R11: hold in the middle of a data byte (0x5A)
        write_bytes(16'h0050, 1, 8'h11);
        select_dev();
        spi_byte(8'h02);
        spi_byte(8'h00);
        spi_byte(8'h50);
        spi_bit(1'b0); spi_bit(1'b1); spi_bit(1'b0); spi_bit(1'b1);
        hold_n = 1'b0;
        wait_clks(4);
        repeat (3) begin
            si = 1'b1;
            sclk = 1'b1;
            wait_clks(4);
            sclk = 1'b0;
            wait_clks(4);
        end
        sclk = 1'b1;
        cs_n = 1'b1;
        wait_clks(6);
        cs_n = 1'b0;
        wait_clks(6);
        hold_n = 1'b1;
        wait_clks(6);
        sclk = 1'b0;
        wait_clks(4);
        spi_bit(1'b1); spi_bit(1'b0); spi_bit(1'b1); spi_bit(1'b0);
        deselect_dev();
        ref_mem[10'h050] = 8'h5A;
        read_bytes(16'h0050, 1, "R11");

        // R12: abort mid-byte
        write_bytes(16'h0060, 1, 8'h22);
        select_dev();
        spi_byte(8'h02);
        spi_byte(8'h00);
        spi_byte(8'h60);
        repeat (4) spi_bit(1'b1);
        deselect_dev();
        check(so === 1'b1, "R1 so after abort", {7'd0, so}, 8'h01);
        read_bytes(16'h0060, 1, "R12");

        read_status(1, "R8");

        check(exp_q.size() == 0, "R7 leftover expected bytes", 8'(exp_q.size()), 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule